// File: doc/BRIEF.md
# Serial EEPROM Byte-Write Slave

This block is the receive side of a two-wire (I2C) slave for a small serial EEPROM, limited to the single-byte write. It oversamples SCL and SDA with the system clock, finds bus Start and Stop conditions, and checks the control byte against its slave identity. It then takes a word address into an internal pointer and captures one data byte. Each accepted byte is answered with an acknowledge pulled onto SDA during the ninth SCL clock.

A Stop that closes a complete, acknowledged byte write launches a self-timed program cycle. The cycle counts a parameterized number of system clocks and then writes the byte into a 128 x 8 register array. A write-enable input guards programming. It must stay high from the Start through the Stop, or the Stop launches nothing. Once the program cycle runs, that input has no effect. While the cycle runs, the slave leaves every control byte unacknowledged. A combinational read port exposes the array to the read datapath that sits beside this block.

Top module: `eeprom_byte_write_slave`

## Requirements
- R1: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start in the middle of a transfer discards it and begins a new control byte.
- R2: A control byte, sent MSB first, is acknowledged when bits 7:4 equal the slave identity (default 4'b1010), bits 3:1 are zero and bit 0 (R/W) is 0. The acknowledge is `sda_pull_o` high during the ninth SCL high phase.
- R3: A control byte with a wrong identity, nonzero bits 3:1, or R/W = 1 is not acknowledged. The slave then ignores the bus until the next Start, and no write follows.
- R4: The byte after an acknowledged control byte is acknowledged and loaded as the word address. Its low 7 bits select the array entry.
- R5: The byte after the word address is acknowledged as data. A Stop after that acknowledge raises `busy_o` within 4 clocks.
- R6: `busy_o` stays high for WR_CYCLES clocks. Then the data byte is written at the addressed entry, and `busy_o` clears.
- R7: While `busy_o` is high, no control byte is acknowledged.
- R8: If `wen_i` is low at any moment between the Start and the Stop, the Stop starts no write. `busy_o` stays low and the array is unchanged.
- R9: After `busy_o` rises, `wen_i` is ignored. Driving it low does not abort the write, and the data is still committed.
- R10: A Stop that arrives before the data byte has been acknowledged starts no write.
- R11: After reset, `sda_pull_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wen_i | input | 1 | Write-enable guard, must be high through the transfer |
| sda_pull_o | output | 1 | High pulls SDA low (acknowledge) |
| busy_o | output | 1 | Self-timed program cycle in progress |
| rd_addr_i | input | 7 | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |

## Verification
Each pad change reaches the event logic two clocks later. One more register then sets the acknowledge or `busy_o`, so both are due three clocks after the bench drives the edge. The bench holds every SCL phase for four clocks and samples the acknowledge in the middle of the ninth high phase. It samples `busy_o` four clocks after the Stop edge. `busy_o` is checked still high a few clocks before WR_CYCLES has elapsed. It is checked low, with the array entry read back, a few clocks after that.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACK_CTRL,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_DATA,
    ST_ACK_DATA,
    ST_HOLD
  } eew_state_e;
endpackage

// File: rtl/eew_line_sync.sv
module eew_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wen_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o,
  output logic wen_o
);
  localparam int unsigned LINES = 3;
  localparam logic [LINES-1:0] IDLE_LVL = 3'b011; // wen low, sda high, scl high

  logic [STAGES-1:0][LINES-1:0] chain_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= IDLE_LVL;
        else        chain_q[s] <= {wen_i, sda_i, scl_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= IDLE_LVL;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign scl_s = chain_q[STAGES-1][0];
  assign sda_s = chain_q[STAGES-1][1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  assign sda_o      = sda_s;
  assign wen_o      = chain_q[STAGES-1][2];

  assert_start_scl_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> scl_prev_q);
endmodule

// File: rtl/eew_xfer_fsm.sv
module eew_xfer_fsm
  import eew_pkg::*;
#(
  parameter int unsigned     ID_W   = 4,
  parameter logic [ID_W-1:0] SLV_ID = 4'b1010,
  parameter int unsigned     PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              wen_i,
  input  logic              busy_i,
  output logic              ack_o,
  output logic              wr_go_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
  localparam int unsigned FIXED_W = BYTE_W - ID_W - 1;

  eew_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   shift_q, shift_d;
  logic [BYTE_W-1:0]   data_q, data_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                ack_q, ack_d;
  logic                wen_ok_q, wen_ok_d;
  logic                byte_full, ctrl_match;

  assign byte_full  = (cnt_q == CNT_W'(BYTE_W));
  assign ctrl_match = (shift_q[BYTE_W-1 -: ID_W] == SLV_ID) &&
                      (shift_q[FIXED_W:1] == '0) && !shift_q[0];

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    data_d   = data_q;
    ptr_d    = ptr_q;
    ack_d    = ack_q;
    wen_ok_d = wen_ok_q & wen_i;
    wr_go_o  = 1'b0;
    if (start_i) begin
      state_d  = ST_CTRL;
      cnt_d    = '0;
      ack_d    = 1'b0;
      wen_ok_d = wen_i;
    end else if (stop_i) begin
      wr_go_o = (state_q == ST_HOLD) && wen_ok_q && wen_i;
      state_d = ST_IDLE;
      ack_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_DATA: begin
          if (scl_rise_i && !byte_full) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_i};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall_i && byte_full) begin
            cnt_d = '0;
            ack_d = 1'b1;
            if (state_q == ST_CTRL) begin
              if (ctrl_match && !busy_i) state_d = ST_ACK_CTRL;
              else begin
                state_d = ST_IDLE;
                ack_d   = 1'b0;
              end
            end else if (state_q == ST_ADDR) begin
              ptr_d   = shift_q[PTR_W-1:0];
              state_d = ST_ACK_ADDR;
            end else begin
              data_d  = shift_q;
              state_d = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_CTRL, ST_ACK_ADDR, ST_ACK_DATA: begin
          if (scl_fall_i) begin
            ack_d = 1'b0;
            if (state_q == ST_ACK_CTRL)      state_d = ST_ADDR;
            else if (state_q == ST_ACK_ADDR) state_d = ST_DATA;
            else                             state_d = ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      data_q   <= '0;
      ptr_q    <= '0;
      ack_q    <= 1'b0;
      wen_ok_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      data_q   <= data_d;
      ptr_q    <= ptr_d;
      ack_q    <= ack_d;
      wen_ok_q <= wen_ok_d;
    end
  end

  assign ack_o  = ack_q;
  assign ptr_o  = ptr_q;
  assign data_o = data_q;

  assert_ack_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(scl_fall_i));
  assert_ctrl_ack_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && state_q == ST_ACK_CTRL) |-> !$past(busy_i));
  assert_bad_ctrl_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CTRL && scl_fall_i && byte_full && !ctrl_match && !start_i && !stop_i)
      |=> state_q == ST_IDLE);
endmodule

// File: rtl/eew_wr_timer.sv
module eew_wr_timer
  import eew_pkg::*;
#(
  parameter int unsigned CYCLES = 5000,
  parameter int unsigned PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              done;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    ptr_d  = ptr_q;
    data_d = data_q;
    if (!busy_q && go_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYCLES - 1);
      ptr_d  = ptr_i;
      data_d = data_i;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      data_q <= data_d;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = done;
  assign ptr_o    = ptr_q;
  assign data_o   = data_q;

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);
  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_q);
  assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(data_q) && $stable(ptr_q));
endmodule

// File: rtl/eew_store.sv
module eew_store
  import eew_pkg::*;
#(
  parameter int unsigned PTR_W = 7
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_byte_write_slave.sv
module eeprom_byte_write_slave
  import eew_pkg::*;
#(
  parameter int unsigned     ID_W        = 4,
  parameter logic [ID_W-1:0] SLV_ID      = 4'b1010,
  parameter int unsigned     PTR_W       = 7,
  parameter int unsigned     WR_CYCLES   = 5000,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wen_i,
  output logic              sda_pull_o,
  output logic              busy_o,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              scl_rise, scl_fall, start_evt, stop_evt, sda_s, wen_s;
  logic              ack, wr_go, commit;
  logic [PTR_W-1:0]  fsm_ptr, wr_ptr;
  logic [BYTE_W-1:0] fsm_data, wr_data;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  eew_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wen_i(wen_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_evt),
    .stop_o(stop_evt), .sda_o(sda_s), .wen_o(wen_s)
  );

  eew_xfer_fsm #(.ID_W(ID_W), .SLV_ID(SLV_ID), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .sda_i(sda_s), .wen_i(wen_s),
    .busy_i(busy_o), .ack_o(ack), .wr_go_o(wr_go), .ptr_o(fsm_ptr), .data_o(fsm_data)
  );

  eew_wr_timer #(.CYCLES(WR_CYCLES), .PTR_W(PTR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(wr_go), .ptr_i(fsm_ptr), .data_i(fsm_data),
    .busy_o(busy_o), .commit_o(commit), .ptr_o(wr_ptr), .data_o(wr_data)
  );

  eew_store #(.PTR_W(PTR_W)) u_store (
    .clk(clk), .we_i(commit), .waddr_i(wr_ptr), .wdata_i(wr_data),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign sda_pull_o = ack;

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_evt));
  assert_busy_needs_wen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wen_s));
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);
endmodule

// File: tb/test_eeprom_byte_write_slave.sv
`timescale 1ns/1ps
module test_eeprom_byte_write_slave;
  localparam int unsigned WRC = 400;
  localparam int unsigned Q   = 4;
  localparam logic [7:0]  CTRL_OK = 8'hA0;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1, wen = 1'b1;
  logic       sda_pull, busy;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sda_bus;

  int checks = 0, errors = 0;
  logic [7:0] model [128];
  bit         known [128];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  eeprom_byte_write_slave #(.WR_CYCLES(WRC)) i_eeprom_byte_write_slave (
    .clk(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus), .wen_i(wen),
    .sda_pull_o(sda_pull), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ctrl_valid(input logic [7:0] c);
    return (c[7:4] == 4'b1010) && (c[3:1] == 3'b000) && !c[0];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = sda_pull;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic check_mem(input logic [6:0] a, input string req);
    if (known[a]) begin
      rd_addr = a; tick(1);
      chk(rd_data == model[a], req, rd_data, model[a]);
    end
  endtask

  // Full byte write; drop_at = byte index at which wen falls (-1 none).
  task automatic write_xact(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d,
                            input int drop_at, input int nbytes, input string req);
    bit ack;
    bit exp_ack;
    bit exp_wr;
    logic [7:0] bytes [3];
    bytes[0] = c; bytes[1] = a; bytes[2] = d;
    exp_ack = ctrl_valid(c) && !busy;
    exp_wr  = exp_ack && (nbytes == 3) && (drop_at < 0);
    wen = 1'b1;
    bus_start();
    for (int i = 0; i < nbytes; i++) begin
      if (drop_at == i) wen = 1'b0;
      send_byte(bytes[i], ack);
      chk(ack == exp_ack, $sformatf("%s ack byte%0d", req, i), ack, exp_ack);
    end
    bus_stop();
    chk(busy == exp_wr, $sformatf("%s busy after stop", req), busy, exp_wr);
    wen = 1'b1;
    if (exp_wr) begin
      tick(WRC - 10);
      chk(busy == 1'b1, "R6 busy held", busy, 1);
      tick(15);
      chk(busy == 1'b0, "R6 busy cleared", busy, 0);
      model[a[6:0]] = d; known[a[6:0]] = 1'b1;
    end
    check_mem(a[6:0], $sformatf("%s array", req));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit ack;
    int unsigned seed;
    logic [7:0] c, a, d;
    int drop, nb;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < 128; i++) known[i] = 1'b0;
    tick(5);
    chk(sda_pull == 1'b0, "R11 pull in reset", sda_pull, 0);
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    rst_ni = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0 && busy == 1'b0, "R11 after release", {sda_pull, busy}, 0);

    // R2 R4 R5 R6: plain write, address MSB ignored for entry select
    write_xact(CTRL_OK, 8'h85, 8'h3C, -1, 3, "R2 R4 R5");
    rd_addr = 7'h05; tick(1);
    chk(rd_data == 8'h3C, "R4 low 7 bits select", rd_data, 8'h3C);

    // R3: wrong identity, R/W set, fixed bits set
    write_xact(8'hB0, 8'h05, 8'h11, -1, 3, "R3 id");
    write_xact(8'hA1, 8'h05, 8'h22, -1, 3, "R3 rw");
    write_xact(8'hA4, 8'h05, 8'h33, -1, 3, "R3 fixed");

    // R8: wen low during data byte
    write_xact(CTRL_OK, 8'h05, 8'h44, 2, 3, "R8 wen drop");
    // R10: stop after the address only
    write_xact(CTRL_OK, 8'h05, 8'h55, -1, 2, "R10 early stop");

    // R1: restart mid-transfer, then a complete write elsewhere
    bus_start();
    send_byte(CTRL_OK, ack);
    send_byte(8'h05, ack);
    chk(ack == 1'b1, "R1 addr ack before restart", ack, 1);
    write_xact(CTRL_OK, 8'h12, 8'h9A, -1, 3, "R1 restart");
    check_mem(7'h05, "R1 old entry untouched");

    // R9 and R7: drop wen and offer a control byte while busy
    bus_start();
    send_byte(CTRL_OK, ack);
    send_byte(8'h20, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    chk(busy == 1'b1, "R9 busy started", busy, 1);
    wen = 1'b0;
    bus_start();
    send_byte(CTRL_OK, ack);
    chk(ack == 1'b0, "R7 no ack while busy", ack, 0);
    bus_stop();
    tick(WRC);
    chk(busy == 1'b0, "R9 write finished", busy, 0);
    model[7'h20] = 8'hC3; known[7'h20] = 1'b1;
    check_mem(7'h20, "R9 committed despite wen low");
    wen = 1'b1;

    // constrained random mix
    for (int n = 0; n < 24; n++) begin
      c    = ($urandom % 10 < 7) ? CTRL_OK : 8'($urandom);
      a    = 8'($urandom);
      d    = 8'($urandom);
      drop = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
      nb   = ($urandom % 7 == 0) ? 2 : 3;
      write_xact(c, a, d, drop, nb, "R2 R3 R8 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule